// File: doc/BRIEF.md
# Four-Bit Adder-Subtracter with Condition Flags

This block adds or subtracts two 4-bit two's-complement operands in a single pass. A mode input selects between sum and difference. For subtraction the second operand is bitwise inverted and a carry-in of one enters the ripple chain. Alongside the 4-bit result the block reports four condition flags: carry, overflow, negative and zero.

The overflow flag is derived only from operand and result signs, so the adder chain never has to expose its upper carries. A parameter places an optional register stage after the arithmetic, which makes the block easy to drive from a clocked bench or to drop into a pipelined path. With the stage removed, the outputs follow the inputs combinationally.

Top module: `addsub_flags`

## Requirements
- R1: With sub_mode = 0, result equals (op_a + op_b) modulo 16.
- R2: With sub_mode = 1, result equals (op_a + ~op_b + 1) modulo 16, which is op_a - op_b in two's complement.
- R3: flag_c is the carry out of bit 3 of the effective addition. In subtract mode it is not inverted, so it is 1 exactly when op_a >= op_b taken as unsigned values.
- R4: flag_v is 1 when the sign bits (bit 3) of op_a and of the effective second operand (op_b, or ~op_b in subtract mode) are both 0 and result bit 3 is 1.
- R5: flag_v is 1 when both effective sign bits are 1 and result bit 3 is 0. In every other case flag_v is 0.
- R6: flag_n equals result bit 3.
- R7: flag_z is 1 exactly when all four result bits are 0.
- R8: With REG_OUT = 1 (default), result and all flags change only on a rising clk edge and reflect the inputs present before that edge. While rst_n is low, result and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| op_a | input | 4 | First operand |
| op_b | input | 4 | Second operand |
| sub_mode | input | 1 | 0 selects add, 1 selects subtract |
| result | output | 4 | Sum or difference |
| flag_c | output | 1 | Carry out of bit 3 |
| flag_v | output | 1 | Signed overflow |
| flag_n | output | 1 | Result sign |
| flag_z | output | 1 | Result is zero |

## Verification
Several flags can be raised by the same operation. The sharpest case is 8 + 8, which wraps to zero and so sets carry, overflow and zero together; subtracting a value from itself sets carry and zero at once. The directed vector table provokes these coincidences and judges every flag separately. A sweep over all 512 operand and mode combinations then compares each output against a reference built from signed integer arithmetic.

// File: rtl/addsub_flags.sv
module addsub_flags #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_mode,
  output logic [W-1:0] result,
  output logic         flag_c,
  output logic         flag_v,
  output logic         flag_n,
  output logic         flag_z
);

  localparam int MSB = W - 1;

  logic [W-1:0] eff_b;
  logic [W:0]   carry;
  logic [W-1:0] sum_c;
  logic         c_c, v_c, n_c, z_c;

  assign eff_b    = op_b ^ {W{sub_mode}};
  assign carry[0] = sub_mode;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign sum_c[i]   = op_a[i] ^ eff_b[i] ^ carry[i];
    assign carry[i+1] = (op_a[i] & eff_b[i]) | (carry[i] & (op_a[i] ^ eff_b[i]));
  end

  assign c_c = carry[W];
  assign v_c = (op_a[MSB] == eff_b[MSB]) && (sum_c[MSB] != op_a[MSB]);
  assign n_c = sum_c[MSB];
  assign z_c = (sum_c == '0);

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result <= '0;
        flag_c <= 1'b0;
        flag_v <= 1'b0;
        flag_n <= 1'b0;
        flag_z <= 1'b0;
      end else begin
        result <= sum_c;
        flag_c <= c_c;
        flag_v <= v_c;
        flag_n <= n_c;
        flag_z <= z_c;
      end
    end

    assert_reg_stage_R8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (result == $past(op_a + (sub_mode ? ~op_b : op_b) + W'(sub_mode))));
  end else begin : g_comb
    assign result = sum_c;
    assign flag_c = c_c;
    assign flag_v = v_c;
    assign flag_n = n_c;
    assign flag_z = z_c;
  end

  assert_add_zero_b_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!sub_mode && op_b == '0) |-> (sum_c == op_a && !c_c));

  assert_sub_self_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_mode && op_a == op_b) |-> (sum_c == '0 && c_c));

  assert_sub_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sub_mode |-> (c_c == (op_a >= op_b)));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_a[MSB] != eff_b[MSB]) |-> !v_c);

  assert_zero_sign_R7: assert property (@(posedge clk) disable iff (!rst_n)
    z_c |-> !n_c);

endmodule

// File: tb/addsub_flags_tb.sv
module addsub_flags_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] op_a = '0, op_b = '0;
  logic       sub_mode = 1'b0;
  logic [3:0] result;
  logic       flag_c, flag_v, flag_n, flag_z;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addsub_flags u_dut (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
    .result(result), .flag_c(flag_c), .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z)
  );

  // {mode, a, b, result, c, v, n, z}
  localparam logic [16:0] VEC [8] = '{
    {1'b0, 4'h3, 4'h4, 4'h7, 4'b0000},
    {1'b0, 4'h7, 4'h1, 4'h8, 4'b0110},
    {1'b0, 4'h8, 4'h8, 4'h0, 4'b1101},
    {1'b0, 4'hF, 4'h1, 4'h0, 4'b1001},
    {1'b1, 4'h5, 4'h5, 4'h0, 4'b1001},
    {1'b1, 4'h0, 4'h8, 4'h8, 4'b0110},
    {1'b1, 4'h3, 4'h5, 4'hE, 4'b0010},
    {1'b1, 4'h8, 4'h1, 4'h7, 4'b1100}
  };

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s a=%0h b=%0h sub=%0b actual=%0h expected=%0h",
               tag, op_a, op_b, sub_mode, act, exp);
    end
  endtask

  task automatic check_all(logic [3:0] er, logic ec, logic ev, logic en, logic ez);
    chk(sub_mode ? "R2 result" : "R1 result", result, er);
    chk("R3 carry", flag_c, ec);
    chk(er[3] ? "R4 overflow" : "R5 overflow", flag_v, ev);
    chk("R6 negative", flag_n, en);
    chk("R7 zero", flag_z, ez);
  endtask

  task automatic apply(logic m, logic [3:0] a, logic [3:0] b);
    @(negedge clk);
    sub_mode = m; op_a = a; op_b = b;
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op_a = 4'h8; op_b = 4'h8;
    repeat (3) @(negedge clk);
    chk("R8 reset result", result, 0);
    chk("R8 reset flags", {flag_c, flag_v, flag_n, flag_z}, 0);
    rst_n = 1'b1;

    foreach (VEC[k]) begin
      apply(VEC[k][16], VEC[k][15:12], VEC[k][11:8]);
      check_all(VEC[k][7:4], VEC[k][3], VEC[k][2], VEC[k][1], VEC[k][0]);
    end

    // R8: output holds until the next rising edge
    apply(1'b0, 4'h2, 4'h2);
    @(negedge clk);
    op_a = 4'h6; op_b = 4'h1;
    #2;
    chk("R8 hold before edge", result, 4'h4);
    @(negedge clk);
    chk("R8 update after edge", result, 4'h7);

    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          int eb, s, sa, sb, tv;
          eb = (m == 1) ? (~b & 15) : b;
          s  = a + eb + m;
          sa = (a >= 8) ? a - 16 : a;
          sb = (b >= 8) ? b - 16 : b;
          tv = (m == 1) ? sa - sb : sa + sb;
          apply(m[0], a[3:0], b[3:0]);
          check_all(s[3:0], s[4], (tv < -8) || (tv > 7), s[3], (s & 15) == 0);
        end
      end
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R8 async reset", {result, flag_c, flag_v, flag_n, flag_z}, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule